// File: doc/BRIEF.md
# Core Register Access Sequencer

This block reads or writes one register of a processor core that has been halted in debug state. It does not touch the core itself. It drives a pipeline injector: each injection puts one 32-bit word into the core's pipeline, and the injector hands back the word captured from the core's data bus in the same transfer. A request carries a register number, a read/write direction, write data, and a core-state bit. That bit says whether the core is running its compact 16-bit instruction set or its full 32-bit set.

For each request the sequencer emits a fixed schedule of no-op words, one register-transfer word and, for writes, data words. It then reports completion. For reads it also returns the captured register contents. The no-op and transfer opcodes are parameters. The sequencer only inserts the register number into the transfer opcode's register fields.

A write runs its schedule twice: first with a zero data word, then with the real value. A program-counter write places the data word earlier in the schedule than a write to an ordinary register does. A compact-mode request for a register above 7 cannot be served directly. It is rejected with an error and no injection.

Top module: `regseq_top`

## Requirements
- R1: A read emits exactly six injections in the order no-op, transfer, no-op, no-op, no-op, no-op. The transfer word is the read opcode with the register fields filled in.
- R2: A write to a register other than 15 uses a five-injection pass in the order no-op, transfer, no-op, no-op, data. The transfer word is the write opcode with the register fields filled in.
- R3: A write to register 15 (the program counter) in 32-bit mode uses a five-injection pass in the order no-op, transfer, data, no-op, no-op.
- R4: Every write performs its pass twice. The first pass carries data 0 and the second carries the requested value. Two trailing no-ops follow, for twelve injections in total.
- R5: The no-op word is the 16-bit no-op opcode when compactMode is 1, and the 32-bit no-op opcode when compactMode is 0. Both values are sampled at the request.
- R6: In 32-bit mode the register number is ORed into transfer bits 15:12. For writes it is also ORed into bits 19:16.
- R7: In 16-bit mode register bits 2:0 are ORed into transfer bits 2:0 and 18:16. For writes they are also ORed into bits 5:3 and 21:19.
- R8: injBrk is 0 on every injection.
- R9: A request with compactMode 1 and a register number above 7 pulses done and error together on the next cycle and makes no injection.
- R10: One cycle after the injector acknowledges the final injection of a sequence, done pulses for one cycle with busy low. For a read, rdData then equals the word captured from the sixth injection.
- R11: While a sequence is running, injValid stays high and injWord stays stable until injDone. A new reqValid is ignored until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqReg | input | 4 | Register number |
| reqData | input | 32 | Write value |
| compactMode | input | 1 | 1 = core runs the 16-bit instruction set |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Pulses with done when a request is rejected |
| rdData | output | 32 | Result of the last read |
| injValid | output | 1 | Injection request to the injector |
| injWord | output | 32 | Word to inject |
| injBrk | output | 1 | Breakpoint flag of the injection |
| injDone | input | 1 | Injector acknowledge, one cycle |
| injCapture | input | 32 | Bus word captured by the acknowledged injection |

## Verification
The bench sweeps every register number in both instruction-set modes, for both reads and writes, and compares the full injected word stream against a schedule it computes itself. The register-15 write separates the program-counter slot ordering from the ordinary write ordering. The per-register field checks separate the 32-bit and 16-bit field placements, and the mode sweep separates the two no-op opcodes. Compact-mode requests for registers 8 to 15 must be rejected with no injection. The injector model acknowledges with a varying latency, and each sequence gets a conflicting request while it runs. Together these show that the held word and the latched request fields are used, not the live ones.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // latch the request fields
    logic selXfer;   // inject the transfer opcode
    logic selData;   // inject a data word
    logic dataZero;  // data word is forced to zero (first write pass)
    logic capture;   // take the bus word as read result
  } seqStrobe_t;

  localparam int STEP_W = 4;
endpackage

// File: rtl/regseq_ctrl.sv
module regseq_ctrl
  import regseq_pkg::*;
#(
  parameter int REG_W    = 4,
  parameter int PC_REG   = 15,
  parameter int LOW_REGS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [REG_W-1:0] reqReg,
  input  logic             compactMode,
  input  logic             injDone,
  output logic             injValid,
  output logic             busy,
  output logic             done,
  output logic             error,
  output seqStrobe_t       strb
);
  localparam int READ_LEN  = 6;
  localparam int PASS_LEN  = 5;
  localparam int TAIL_LEN  = 2;
  localparam int WRITE_LEN = 2 * PASS_LEN + TAIL_LEN;
  localparam int XFER_POS  = 1;
  localparam int PC_DATA_POS  = 2;
  localparam int REG_DATA_POS = PASS_LEN - 1;

  typedef enum logic {S_IDLE, S_RUN} state_t;

  state_t            state;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] passPos;
  logic              wrLatched;
  logic              pcLatched;
  logic              badReq;
  logic              lastStep;
  logic              inPasses;

  assign badReq   = compactMode && (int'(reqReg) >= LOW_REGS);
  assign inPasses = int'(step) < 2 * PASS_LEN;
  assign passPos  = (int'(step) >= PASS_LEN) ? step - STEP_W'(PASS_LEN) : step;
  assign lastStep = wrLatched ? (int'(step) == WRITE_LEN - 1)
                              : (int'(step) == READ_LEN - 1);
  assign busy     = (state == S_RUN);
  assign injValid = busy;

  always_comb begin
    strb          = '0;
    strb.load     = (state == S_IDLE) && reqValid && !badReq;
    strb.dataZero = int'(step) < PASS_LEN;
    if (busy) begin
      if (wrLatched) begin
        strb.selXfer = inPasses && (int'(passPos) == XFER_POS);
        strb.selData = inPasses &&
          (int'(passPos) == (pcLatched ? PC_DATA_POS : REG_DATA_POS));
      end else begin
        strb.selXfer = (int'(step) == XFER_POS);
        strb.capture = injDone && lastStep;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      step      <= '0;
      wrLatched <= 1'b0;
      pcLatched <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (state)
        S_IDLE: begin
          if (reqValid) begin
            if (badReq) begin
              done  <= 1'b1;
              error <= 1'b1;
            end else begin
              state     <= S_RUN;
              step      <= '0;
              wrLatched <= reqWrite;
              pcLatched <= reqWrite && !compactMode && (int'(reqReg) == PC_REG);
            end
          end
        end
        default: begin
          if (injDone) begin
            if (lastStep) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              step <= step + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/regseq_dp.sv
module regseq_dp
  import regseq_pkg::*;
#(
  parameter int          REG_W    = 4,
  parameter int          DATA_W   = 32,
  parameter int          LOW_W    = 3,
  parameter logic [31:0] NOP32    = 32'hE1A0_0000,
  parameter logic [31:0] NOP16    = 32'h46C0_46C0,
  parameter logic [31:0] READ32   = 32'hE580_0000,
  parameter logic [31:0] WRITE32  = 32'hE590_0000,
  parameter logic [31:0] READ16   = 32'h6000_6000,
  parameter logic [31:0] WRITE16  = 32'h6800_6800
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              reqWrite,
  input  logic [REG_W-1:0]  reqReg,
  input  logic [DATA_W-1:0] reqData,
  input  logic              compactMode,
  input  logic [DATA_W-1:0] injCapture,
  output logic [DATA_W-1:0] injWord,
  output logic              injBrk,
  output logic [DATA_W-1:0] rdData
);
  localparam int FULL_LO_A = 12;
  localparam int FULL_LO_B = 16;
  localparam int CMP_LO_A  = 0;
  localparam int CMP_LO_B  = 16;
  localparam int CMP_LO_C  = 3;
  localparam int CMP_LO_D  = 19;

  logic [REG_W-1:0]  regL;
  logic [DATA_W-1:0] dataL;
  logic              wrL;
  logic              compactL;
  logic [DATA_W-1:0] nopWord;
  logic [DATA_W-1:0] xferWord;
  logic [DATA_W-1:0] fullReg;
  logic [DATA_W-1:0] lowReg;

  assign fullReg = DATA_W'(regL);
  assign lowReg  = DATA_W'(regL[LOW_W-1:0]);
  assign nopWord = compactL ? NOP16 : NOP32;

  always_comb begin
    if (compactL) begin
      xferWord = (wrL ? WRITE16 : READ16) | (lowReg << CMP_LO_A) | (lowReg << CMP_LO_B);
      if (wrL) xferWord = xferWord | (lowReg << CMP_LO_C) | (lowReg << CMP_LO_D);
    end else begin
      xferWord = (wrL ? WRITE32 : READ32) | (fullReg << FULL_LO_A);
      if (wrL) xferWord = xferWord | (fullReg << FULL_LO_B);
    end
  end

  always_comb begin
    if (strb.selXfer)      injWord = xferWord;
    else if (strb.selData) injWord = strb.dataZero ? '0 : dataL;
    else                   injWord = nopWord;
  end

  assign injBrk = 1'b0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regL     <= '0;
      dataL    <= '0;
      wrL      <= 1'b0;
      compactL <= 1'b0;
      rdData   <= '0;
    end else begin
      if (strb.load) begin
        regL     <= reqReg;
        dataL    <= reqData;
        wrL      <= reqWrite;
        compactL <= compactMode;
      end
      if (strb.capture) rdData <= injCapture;
    end
  end
endmodule

// File: rtl/regseq_top.sv
module regseq_top #(
  parameter int          REG_W    = 4,
  parameter int          DATA_W   = 32,
  parameter int          PC_REG   = 15,
  parameter int          LOW_REGS = 8,
  parameter logic [31:0] NOP32    = 32'hE1A0_0000,
  parameter logic [31:0] NOP16    = 32'h46C0_46C0,
  parameter logic [31:0] READ32   = 32'hE580_0000,
  parameter logic [31:0] WRITE32  = 32'hE590_0000,
  parameter logic [31:0] READ16   = 32'h6000_6000,
  parameter logic [31:0] WRITE16  = 32'h6800_6800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [REG_W-1:0]  reqReg,
  input  logic [DATA_W-1:0] reqData,
  input  logic              compactMode,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [DATA_W-1:0] rdData,
  output logic              injValid,
  output logic [DATA_W-1:0] injWord,
  output logic              injBrk,
  input  logic              injDone,
  input  logic [DATA_W-1:0] injCapture
);
  localparam int LOW_W = $clog2(LOW_REGS);

  regseq_pkg::seqStrobe_t strb;

  regseq_ctrl #(.REG_W(REG_W), .PC_REG(PC_REG), .LOW_REGS(LOW_REGS)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReg(reqReg), .compactMode(compactMode), .injDone(injDone),
    .injValid(injValid), .busy(busy), .done(done), .error(error), .strb(strb)
  );

  regseq_dp #(
    .REG_W(REG_W), .DATA_W(DATA_W), .LOW_W(LOW_W),
    .NOP32(NOP32), .NOP16(NOP16), .READ32(READ32), .WRITE32(WRITE32),
    .READ16(READ16), .WRITE16(WRITE16)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWrite(reqWrite), .reqReg(reqReg),
    .reqData(reqData), .compactMode(compactMode), .injCapture(injCapture),
    .injWord(injWord), .injBrk(injBrk), .rdData(rdData)
  );
endmodule

// File: rtl/regseq_checker.sv
module regseq_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              injValid,
  input logic [DATA_W-1:0] injWord,
  input logic              injBrk,
  input logic              injDone
);
  assert_brk_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    injValid |-> !injBrk);

  assert_reject_no_access_R9: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (done && !injValid && !$past(busy)));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !injValid));

  assert_hold_word_R11: assert property (@(posedge clk) disable iff (!rstN)
    (injValid && !injDone) |=> (injValid && $stable(injWord)));

  assert_valid_is_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    injValid == busy);
endmodule

bind regseq_top regseq_checker #(.DATA_W(DATA_W)) checker_i (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .error(error),
  .injValid(injValid), .injWord(injWord), .injBrk(injBrk), .injDone(injDone)
);

// File: tb/regseq_top_tb_top.sv
module regseq_top_tb_top;
  localparam logic [31:0] N32 = 32'hE1A0_0000;
  localparam logic [31:0] N16 = 32'h46C0_46C0;
  localparam logic [31:0] R32 = 32'hE580_0000;
  localparam logic [31:0] W32 = 32'hE590_0000;
  localparam logic [31:0] R16 = 32'h6000_6000;
  localparam logic [31:0] W16 = 32'h6800_6800;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [3:0]  reqReg = '0;
  logic [31:0] reqData = '0;
  logic        compactMode = 1'b0;
  logic        busy, done, error, injValid, injBrk;
  logic [31:0] rdData, injWord;
  logic        injDone = 1'b0;
  logic [31:0] injCapture = '0;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic [31:0] logW [16];
  int          nInj = 0;
  int          lat = 0;
  logic        brkSeen = 1'b0;
  logic [31:0] capBase = 32'h5A00_0000;

  always #2 clk = ~clk;

  regseq_top dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReg(reqReg), .reqData(reqData), .compactMode(compactMode),
    .busy(busy), .done(done), .error(error), .rdData(rdData),
    .injValid(injValid), .injWord(injWord), .injBrk(injBrk),
    .injDone(injDone), .injCapture(injCapture)
  );

  // Injector model with varying acknowledge latency
  always @(negedge clk) begin
    if (injDone) injDone = 1'b0;
    else if (injValid) begin
      if (lat == 0) begin
        if (nInj < 16) logW[nInj] = injWord;
        if (injBrk) brkSeen = 1'b1;
        injCapture = capBase + 32'(nInj);
        nInj = nInj + 1;
        injDone = 1'b1;
        lat = nInj % 3;
      end else lat = lat - 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] xferExp(input logic wr, input logic [3:0] r, input logic cm);
    logic [31:0] w;
    logic [31:0] lo;
    lo = 32'(r[2:0]);
    if (cm) begin
      w = (wr ? W16 : R16) + lo + lo * 32'h1_0000;
      if (wr) w = w + lo * 8 + lo * 32'h8_0000;
    end else begin
      w = (wr ? W32 : R32) + 32'(r) * 32'h1000;
      if (wr) w = w + 32'(r) * 32'h1_0000;
    end
    return w;
  endfunction

  // Expected word at position idx; kind: 0 nop, 1 xfer, 2 data
  function automatic logic [31:0] expWord(input int idx, input logic wr, input logic [3:0] r,
                                          input logic cm, input logic [31:0] d);
    logic [31:0] nop;
    int pos;
    nop = cm ? N16 : N32;
    if (!wr) return (idx == 1) ? xferExp(wr, r, cm) : nop;
    if (idx >= 10) return nop;
    pos = idx % 5;
    if (pos == 1) return xferExp(wr, r, cm);
    if ((!cm && r == 4'd15) ? (pos == 2) : (pos == 4)) return (idx < 5) ? 32'h0 : d;
    return nop;
  endfunction

  task automatic runAccess(input logic wr, input logic [3:0] r, input logic cm, input logic [31:0] d);
    logic doneSeen;
    logic errSeen;
    logic expErr;
    int   expLen;
    nInj = 0; brkSeen = 1'b0; lat = int'(r) % 2;
    capBase = 32'h5A00_0000 + 32'(r) * 32'h100 + (cm ? 32'h10 : 32'h0);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqReg = r; reqData = d; compactMode = cm;
    @(negedge clk);
    reqValid = 1'b0;
    doneSeen = done; errSeen = error;
    if (busy) begin
      // conflicting request while running: must be ignored (R11)
      reqValid = 1'b1; reqWrite = !wr; reqReg = ~r; reqData = ~d;
      @(negedge clk);
      reqValid = 1'b0;
    end
    for (int k = 0; k < 300 && !doneSeen; k++) begin
      @(negedge clk);
      if (done) begin doneSeen = 1'b1; errSeen = error; end
    end
    expErr = cm && (r > 4'd7);
    expLen = expErr ? 0 : (wr ? 12 : 6);
    check(doneSeen, "R10 done pulse", 32'(doneSeen), 32'd1);
    check(errSeen == expErr, "R9 error flag", 32'(errSeen), 32'(expErr));
    check(nInj == expLen, wr ? "R4 write injection count" : "R1 read injection count",
          32'(nInj), 32'(expLen));
    check(!brkSeen, "R8 breakpoint flag", 32'(brkSeen), 32'd0);
    if (!expErr && nInj == expLen) begin
      for (int i = 0; i < expLen; i++) begin
        logic [31:0] e;
        e = expWord(i, wr, r, cm, d);
        check(logW[i] == e,
              !wr ? "R1/R5/R6/R7/R11 read word" :
              (!cm && r == 4'd15) ? "R3/R4 pc write word" : "R2/R4/R5/R6/R7 write word",
              logW[i], e);
      end
      if (!wr) check(rdData == capBase + 32'd5, "R10 read result", rdData, capBase + 32'd5);
    end
    @(negedge clk);
    check(!busy && !done, "R10 idle after done", {30'd0, busy, done}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !error && !injValid, "R10 reset state",
          {28'd0, busy, done, error, injValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    for (int cm = 0; cm < 2; cm++)
      for (int r = 0; r < 16; r++)
        for (int wr = 0; wr < 2; wr++)
          runAccess(wr[0], r[3:0], cm[0], 32'hC3A5_0000 ^ (32'(r) * 32'h0101_0101) ^ 32'(cm * 7));
    // specific values on register 15 and register 0
    runAccess(1'b1, 4'd15, 1'b0, 32'hFFFF_FFFF);
    runAccess(1'b0, 4'd15, 1'b0, 32'h0);
    runAccess(1'b1, 4'd0, 1'b1, 32'h8000_0001);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule